// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sits beside a small microcontroller core and decides which clocks run. It has three operating modes: run, idle and power-down. Software asks for idle or power-down with single-cycle strobes. An external reset pin is accepted only after it has been held high long enough. The block drives a CPU clock enable, a peripheral clock enable, an oscillator enable, a synchronous core reset and a RAM write block.

In idle the CPU clock stops. The peripheral clock keeps running, so RAM, the timers, the serial port and the interrupt logic stay live. Idle ends on an enabled interrupt or on a hardware reset. In power-down every clock stops, including the oscillator, and state is frozen. Only the reset pin can wake the part from power-down. The oscillator is restarted first. Once the reset is accepted, the core reset is held for a fixed settling time before the clocks return.

The pin is synchronised and then counted in machine cycles of `MC_CLKS` oscillator clocks. A reset that ends idle first lets the CPU resume, with RAM writes blocked, until the reset is accepted.

The states and their transitions are:
- **RUN**
  - to RST_HOLD when the reset is qualified
  - else to PDOWN on a power-down strobe
  - else to IDLE on an idle strobe
- **IDLE**
  - to RST_HOLD when the reset is qualified
  - else to IDLE_RWIN when the synchronised pin is high
  - else to RUN on an interrupt
- **IDLE_RWIN**
  - to RST_HOLD when the reset is qualified
  - to RUN if the pin drops first
- **PDOWN**
  - to OSC_WAIT when the synchronised pin is high
- **OSC_WAIT**
  - to OSC_STAB when the reset is qualified
  - back to PDOWN if the pin drops first
- **OSC_STAB**
  - to RST_HOLD after `STAB_CYCLES` cycles
- **RST_HOLD**
  - to RUN once the synchronised pin is low

Power-on reset (`rst_n` low) forces RST_HOLD.

Top module: `lpm_rst_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs read as follows: `core_rst`=1, `cpu_clk_en`=1, `periph_clk_en`=1, `osc_en`=1, `ram_wr_block`=0. One cycle after `rst_n` rises with the pin low, the block is in run: enables 1,1,1, `core_rst`=0, `ram_wr_block`=0.
- R2: An `idle_req` strobe in run, without `pdown_req`, gives `cpu_clk_en`=0 on the next cycle, with `periph_clk_en`=1 and `osc_en`=1.
- R3: In idle, with the pin low, `irq` returns the block to run on the next cycle. Without `irq` it stays in idle.
- R4: A `pdown_req` strobe in run gives `cpu_clk_en`, `periph_clk_en` and `osc_en` all 0 on the next cycle. This holds even if `idle_req` arrives in the same cycle.
- R5: In power-down, `irq`, `idle_req` and `pdown_req` have no effect. All outputs stay 0 while the pin is low.
- R6: A reset is accepted after 2×`MC_CLKS` (24) consecutive high samples of the synchronised pin. `core_rst` rises `SYNC_STAGES`+24+1 = 27 cycles after the pin rises in run. A pulse of 23 cycles has no effect.
- R7: In idle, a high pin switches to a resume window 3 cycles later. In that window `cpu_clk_en`=1, `periph_clk_en`=1, `ram_wr_block`=1 and `core_rst`=0.
  - If the pin stays high, reset takes over 27 cycles after it rose.
  - If the pin drops first, the block returns to run 3 cycles after the drop.
- R8: In power-down, a high pin sets `osc_en`=1 3 cycles later, with `core_rst`=0. If the pin falls before it is accepted, the block goes back to power-down 3 cycles after the fall.
- R9: On a wake from power-down, `core_rst` rises 28 cycles after the pin rises. The CPU and peripheral clocks then stay off for `STAB_CYCLES` cycles, after which they turn on with `core_rst` still 1.
- R10: While the reset is held, `idle_req` and `pdown_req` are ignored. The hold ends, entering run, 3 cycles after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, one oscillator period |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| idle_req | input | 1 | Single-cycle request to enter idle |
| pdown_req | input | 1 | Single-cycle request to enter power-down |
| irq | input | 1 | OR of all enabled interrupt requests |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral, timer and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Synchronous core reset, active high |
| ram_wr_block | output | 1 | Blocks internal RAM writes during the idle-to-reset window |

## Verification
The reset pin is driven with pulses of 5, 10, 23 and 24 or more cycles. This separates:
- an off-by-one in the qualification count;
- a glitch that must be rejected;
- a wake that must be aborted.

The same long pulse is applied in run, idle and power-down, so each state's exit path is timed separately. Mode strobes are sent alone, together, and in states that must ignore them. This tells the power-down priority apart from request filtering. Interrupts are sent in both idle and power-down, to show that only idle responds.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_IDLE_RWIN = 3'd2,
        ST_PDOWN     = 3'd3,
        ST_OSC_WAIT  = 3'd4,
        ST_OSC_STAB  = 3'd5,
        ST_RST_HOLD  = 3'd6
    } lpm_state_e;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic osc_en;
        logic core_rst;
        logic ram_blk;
    } lpm_ctl_t;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
    parameter int MC_CLKS = 12,
    parameter int QUAL_MC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin_s,
    output logic ok
);
    localparam int QUAL = MC_CLKS * QUAL_MC;
    localparam int CW   = $clog2(QUAL + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!en || !pin_s)     cnt <= '0;
        else if (cnt != CW'(QUAL))  cnt <= cnt + 1'b1;
    end

    assign ok = (cnt == CW'(QUAL));
endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic       pdown_req,
    input  logic       irq,
    input  logic       pin_s,
    input  logic       rst_ok,
    input  logic       stab_done,
    output lpm_state_e state,
    output lpm_ctl_t   ctl
);
    lpm_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RST_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (rst_ok)         nxt = ST_RST_HOLD;
                else if (pdown_req) nxt = ST_PDOWN;
                else if (idle_req)  nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (rst_ok)         nxt = ST_RST_HOLD;
                else if (pin_s)     nxt = ST_IDLE_RWIN;
                else if (irq)       nxt = ST_RUN;
            end
            ST_IDLE_RWIN: begin
                if (rst_ok)         nxt = ST_RST_HOLD;
                else if (!pin_s)    nxt = ST_RUN;
            end
            ST_PDOWN: begin
                if (pin_s)          nxt = ST_OSC_WAIT;
            end
            ST_OSC_WAIT: begin
                if (rst_ok)         nxt = ST_OSC_STAB;
                else if (!pin_s)    nxt = ST_PDOWN;
            end
            ST_OSC_STAB: begin
                if (stab_done)      nxt = ST_RST_HOLD;
            end
            ST_RST_HOLD: begin
                if (!pin_s)         nxt = ST_RUN;
            end
            default:                nxt = ST_RST_HOLD;
        endcase
    end

    always_comb begin
        ctl = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, core_rst: 1'b0, ram_blk: 1'b0};
        unique case (state)
            ST_RUN:       ;
            ST_IDLE:      ctl.cpu_en = 1'b0;
            ST_IDLE_RWIN: ctl.ram_blk = 1'b1;
            ST_PDOWN: begin
                ctl.cpu_en = 1'b0;
                ctl.per_en = 1'b0;
                ctl.osc_en = 1'b0;
            end
            ST_OSC_WAIT: begin
                ctl.cpu_en = 1'b0;
                ctl.per_en = 1'b0;
            end
            ST_OSC_STAB: begin
                ctl.cpu_en   = 1'b0;
                ctl.per_en   = 1'b0;
                ctl.core_rst = 1'b1;
            end
            ST_RST_HOLD:  ctl.core_rst = 1'b1;
            default:      ctl.core_rst = 1'b1;
        endcase
    end
endmodule

// File: rtl/lpm_rst_ctrl.sv
module lpm_rst_ctrl
    import lpm_pkg::*;
#(
    parameter int MC_CLKS     = 12,
    parameter int QUAL_MC     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int STAB_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic idle_req,
    input  logic pdown_req,
    input  logic irq,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic osc_en,
    output logic core_rst,
    output logic ram_wr_block
);
    logic       pin_s;
    logic       rst_ok;
    logic       stab_done;
    lpm_state_e state;
    lpm_ctl_t   ctl;

    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rst_pin), .q(pin_s)
    );

    lpm_rst_qual #(.MC_CLKS(MC_CLKS), .QUAL_MC(QUAL_MC)) u_qual (
        .clk(clk), .rst_n(rst_n), .en(ctl.osc_en), .pin_s(pin_s), .ok(rst_ok)
    );

    lpm_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
        .clk(clk), .rst_n(rst_n), .run(state == ST_OSC_STAB), .done(stab_done)
    );

    lpm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pdown_req(pdown_req),
        .irq(irq), .pin_s(pin_s), .rst_ok(rst_ok), .stab_done(stab_done),
        .state(state), .ctl(ctl)
    );

    assign cpu_clk_en    = ctl.cpu_en;
    assign periph_clk_en = ctl.per_en;
    assign osc_en        = ctl.osc_en;
    assign core_rst      = ctl.core_rst;
    assign ram_wr_block  = ctl.ram_blk;
endmodule

// File: rtl/lpm_rst_ctrl_chk.sv
module lpm_rst_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic idle_req,
    input logic pdown_req,
    input logic irq,
    input logic pin_s,
    input logic rst_ok,
    input logic cpu_clk_en,
    input logic periph_clk_en,
    input logic osc_en,
    input logic core_rst,
    input logic ram_wr_block
);
    logic in_run, in_idle;
    assign in_run  = cpu_clk_en && periph_clk_en && !core_rst && !ram_wr_block;
    assign in_idle = !cpu_clk_en && periph_clk_en && !core_rst;

    // R2
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && idle_req && !pdown_req && !rst_ok) |=> (!cpu_clk_en && periph_clk_en && osc_en));

    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && irq && !pin_s && !rst_ok) |=> cpu_clk_en);

    // R4
    pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && pdown_req && !rst_ok) |=> (!osc_en && !cpu_clk_en && !periph_clk_en));

    // R5
    pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !pin_s) |=> !osc_en);

    // R6
    rst_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(pin_s, 2));

    // R7
    ram_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_block |-> (cpu_clk_en && !core_rst));

    // R8
    osc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !core_rst);

    // R9
    stab_keep_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && !cpu_clk_en) |=> core_rst);

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && cpu_clk_en && pin_s) |=> core_rst);
endmodule

bind lpm_rst_ctrl lpm_rst_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pdown_req(pdown_req),
    .irq(irq), .pin_s(pin_s), .rst_ok(rst_ok), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .core_rst(core_rst),
    .ram_wr_block(ram_wr_block)
);

// File: tb/lpm_rst_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_rst_ctrl_tb;
    localparam int STAB = 40;
    // output vector order: {cpu, periph, osc, core_rst, ram_block}
    localparam logic [4:0] V_RUN   = 5'b11100;
    localparam logic [4:0] V_IDLE  = 5'b01100;
    localparam logic [4:0] V_RWIN  = 5'b11101;
    localparam logic [4:0] V_PDN   = 5'b00000;
    localparam logic [4:0] V_OWAIT = 5'b00100;
    localparam logic [4:0] V_STAB  = 5'b00110;
    localparam logic [4:0] V_HOLD  = 5'b11110;

    logic clk = 1'b0;
    logic rst_n = 1'b0, rst_pin = 1'b0, idle_req = 1'b0, pdown_req = 1'b0, irq = 1'b0;
    logic cpu_clk_en, periph_clk_en, osc_en, core_rst, ram_wr_block;

    int unsigned cyc = 0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    int unsigned q_cyc[$];
    logic [4:0]  q_exp[$];
    string       q_req[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpm_rst_ctrl #(.STAB_CYCLES(STAB)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req),
        .pdown_req(pdown_req), .irq(irq), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .core_rst(core_rst),
        .ram_wr_block(ram_wr_block)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_at(input int k, input logic [4:0] v, input string r);
        q_cyc.push_back(cyc + k);
        q_exp.push_back(v);
        q_req.push_back(r);
    endtask

    // monitor: pops expectations and compares at their cycle
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            automatic int unsigned c = q_cyc.pop_front();
            automatic logic [4:0]  e = q_exp.pop_front();
            automatic string       r = q_req.pop_front();
            automatic logic [4:0]  a = {cpu_clk_en, periph_clk_en, osc_en, core_rst, ram_wr_block};
            checks++;
            if (c != cyc || a !== e) begin
                fails++;
                $display("FAIL %s cycle %0d: actual %b expected %b (due %0d)", r, cyc, a, e, c);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(1);
        exp_at(1, V_HOLD, "R1");
        step(2);
        rst_n = 1'b1;
        exp_at(1, V_RUN, "R1");
        step(3);

        // R2 idle entry, R3 stays idle then wakes on irq
        idle_req = 1'b1; exp_at(1, V_IDLE, "R2");
        step(1); idle_req = 1'b0;
        exp_at(3, V_IDLE, "R3");
        step(4);
        irq = 1'b1; exp_at(1, V_RUN, "R3");
        step(1); irq = 1'b0;
        step(2);

        // R4 power-down wins over idle
        idle_req = 1'b1; pdown_req = 1'b1; exp_at(1, V_PDN, "R4");
        step(1); idle_req = 1'b0; pdown_req = 1'b0;
        step(1);

        // R5 requests and irq ignored in power-down
        irq = 1'b1; idle_req = 1'b1; pdown_req = 1'b1;
        exp_at(1, V_PDN, "R5"); exp_at(3, V_PDN, "R5");
        step(1); irq = 1'b0; idle_req = 1'b0; pdown_req = 1'b0;
        step(3);

        // R8 short pin pulse: oscillator restarts, then back to power-down
        rst_pin = 1'b1;
        exp_at(2, V_PDN, "R8"); exp_at(3, V_OWAIT, "R8");
        exp_at(7, V_OWAIT, "R8"); exp_at(8, V_PDN, "R8");
        step(5); rst_pin = 1'b0;
        step(6);

        // R9 full wake with settling period
        rst_pin = 1'b1;
        exp_at(27, V_OWAIT, "R9"); exp_at(28, V_STAB, "R9");
        exp_at(27 + STAB, V_STAB, "R9"); exp_at(28 + STAB, V_HOLD, "R9");
        step(30 + STAB);

        // R10 strobes ignored during hold, release after pin drop
        idle_req = 1'b1; pdown_req = 1'b1; exp_at(1, V_HOLD, "R10");
        step(1); idle_req = 1'b0; pdown_req = 1'b0;
        step(2);
        rst_pin = 1'b0;
        exp_at(2, V_HOLD, "R10"); exp_at(3, V_RUN, "R10");
        step(5);

        // R6 23-cycle pulse rejected, 24+ accepted at cycle 27
        rst_pin = 1'b1; exp_at(26, V_RUN, "R6");
        step(23); rst_pin = 1'b0;
        exp_at(7, V_RUN, "R6");
        step(10);
        rst_pin = 1'b1;
        exp_at(26, V_RUN, "R6"); exp_at(27, V_HOLD, "R6");
        step(30); rst_pin = 1'b0;
        exp_at(3, V_RUN, "R6");
        step(5);

        // R7 idle then short pin pulse: resume window, back to run
        idle_req = 1'b1; exp_at(1, V_IDLE, "R7");
        step(1); idle_req = 1'b0;
        rst_pin = 1'b1;
        exp_at(2, V_IDLE, "R7"); exp_at(3, V_RWIN, "R7");
        exp_at(12, V_RWIN, "R7"); exp_at(13, V_RUN, "R7");
        step(10); rst_pin = 1'b0;
        step(5);

        // R7 idle then long pin: resume window then reset
        idle_req = 1'b1; exp_at(1, V_IDLE, "R7");
        step(1); idle_req = 1'b0;
        rst_pin = 1'b1;
        exp_at(3, V_RWIN, "R7"); exp_at(26, V_RWIN, "R7"); exp_at(27, V_HOLD, "R7");
        step(30); rst_pin = 1'b0;
        exp_at(3, V_RUN, "R7");
        step(5);

        // R4 plain power-down from run
        pdown_req = 1'b1; exp_at(1, V_PDN, "R4");
        step(1); pdown_req = 1'b0;
        step(3);

        while (q_cyc.size() > 0) step(1);
        step(1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule